// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a down-counting interval timer with a small memory-mapped register interface. A main counter steps down once per prescaled tick. When it passes zero it either wraps to all ones (free-running) or reloads from a programmable load value (periodic). Each time the counter takes the value held in the compare register, a sticky flag is set. That flag can raise an interrupt line and can toggle, clear or set an output pin.

Software starts and stops the timer through an enable bit. A restart-mode bit chooses what happens on re-enable: counting either resumes from where it stopped or starts again from the top. Three low-power mode inputs (stop, wait, debug) each freeze counting unless their own run-enable bit is set. A freeze caused by a low-power mode always ends with counting resuming from the held value. A load write can optionally overwrite the running counter. A self-clearing software reset returns everything to the reset state except the enable and low-power policy bits. Everything runs on one clock. The clock-select field only decides whether ticks are allowed.

Top module: `tick_timer`

## Requirements
- R1: After reset, control reads 0, status reads 0, load reads 0xFFFFFFFF, compare reads 0, counter reads 0xFFFFFFFF, and irq, pin_out and pin_oe are 0. Register offsets: control 0x00, status 0x04, load 0x08, compare 0x0C, counter 0x10.
- R2: Reads and writes to status, load and compare complete with bus_ready high in the cycle they are presented. A control write sees bus_ready low for exactly one cycle and takes effect at the edge on which bus_ready is high.
- R3: A write to the counter offset returns bus_err high together with bus_ready and leaves the counter unchanged. Reserved control bits (20, 26 to 31) and status bits 31:1 read as 0.
- R4: Control bits [15:4] hold a divider value P. While counting is permitted, the counter decrements once every P+1 clock cycles.
- R5: With control bit 3 (reload) at 0, a counter at 0 becomes 0xFFFFFFFF on the next tick. With bit 3 at 1, it becomes the load value instead.
- R6: Clearing control bit 0 (enable) freezes the counter and the divider. If control bit 1 (restart mode) is 1, a 0-to-1 enable write loads the counter with the load value (reload=1) or 0xFFFFFFFF (reload=0) and clears the divider. If bit 1 is 0, counting resumes from the frozen value.
- R7: While stop_mode, wait_mode or debug_mode is high and the matching run-enable bit is 0, counting freezes. The run-enable bits are control bit 21 (stop), bit 19 (wait) and bit 18 (debug). When the mode input falls, counting resumes from the frozen value regardless of bit 1. With the run-enable bit at 1, counting continues during the mode.
- R8: With control bit 17 (overwrite) at 1, a load write also places the written value in the counter at the same edge, in either reload setting. With bit 17 at 0, the counter is untouched.
- R9: Status bit 0 is set on the tick on which the counter takes the compare value. Writing 1 to it clears it, and a set in the same cycle wins over the clear. irq equals status bit 0 AND control bit 2.
- R10: Control bits [23:22] select the pin action on each compare event: 00 pin_oe low and pin unchanged, 01 toggle, 10 drive low, 11 drive high. pin_oe is high for codes other than 00.
- R11: Writing control with bit 16 set resets all registers, the divider and the pin, but keeps control bits 0, 1, 18, 19 and 21. Bit 16 reads 1 for the one cycle after that write and 0 afterwards.
- R12: With control bits [25:24] at 00 no counting takes place. Any other code permits counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, held until bus_ready |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| bus_ready | output | 1 | Access completes this cycle |
| bus_err | output | 1 | Transfer error (write to counter) |
| stop_mode | input | 1 | Stop low-power mode active |
| wait_mode | input | 1 | Wait low-power mode active |
| debug_mode | input | 1 | Debug halt active |
| irq | output | 1 | Compare interrupt request |
| pin_out | output | 1 | Compare output pin level |
| pin_oe | output | 1 | Output pin drive enable |

## Verification
The checks assume the bus master holds bus_wr, bus_addr and bus_wdata steady until bus_ready is seen, and never raises bus_rd and bus_wr together. The compare-flag check also assumes the compare register is not rewritten on the edge the flag rises. The bench drives every input at the falling edge and keeps each write asserted through its wait state. It issues one access at a time and writes compare only while the timer is disabled or far from a match.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 12;
    localparam int SWR_BIT = 16;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] A_LOAD = 5'h08;
    localparam logic [ADDR_W-1:0] A_CMP  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_CNT  = 5'h10;

    typedef enum logic [1:0] {
        PIN_OFF  = 2'b00,
        PIN_FLIP = 2'b01,
        PIN_LO   = 2'b10,
        PIN_HI   = 2'b11
    } pin_act_e;

    typedef struct packed {
        logic [1:0]       clk_sel;
        pin_act_e         pin_act;
        logic             stop_run;
        logic             wait_run;
        logic             dbg_run;
        logic             ovw;
        logic [DIV_W-1:0] div;
        logic             reload;
        logic             irq_en;
        logic             restart_mode;
        logic             en;
    } ctl_t;

    function automatic ctl_t ctl_unpack(input logic [DATA_W-1:0] w);
        ctl_t c;
        c.en           = w[0];
        c.restart_mode = w[1];
        c.irq_en       = w[2];
        c.reload       = w[3];
        c.div          = w[15:4];
        c.ovw          = w[17];
        c.dbg_run      = w[18];
        c.wait_run     = w[19];
        c.stop_run     = w[21];
        c.pin_act      = pin_act_e'(w[23:22]);
        c.clk_sel      = w[25:24];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_pack(input ctl_t c, input logic busy);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[0]     = c.en;
        w[1]     = c.restart_mode;
        w[2]     = c.irq_en;
        w[3]     = c.reload;
        w[15:4]  = c.div;
        w[16]    = busy;
        w[17]    = c.ovw;
        w[18]    = c.dbg_run;
        w[19]    = c.wait_run;
        w[21]    = c.stop_run;
        w[23:22] = c.pin_act;
        w[25:24] = c.clk_sel;
        return w;
    endfunction

    // Policy bits that survive a software reset.
    function automatic ctl_t ctl_keep(input ctl_t c);
        ctl_t k;
        k              = '0;
        k.en           = c.en;
        k.restart_mode = c.restart_mode;
        k.dbg_run      = c.dbg_run;
        k.wait_run     = c.wait_run;
        k.stop_run     = c.stop_run;
        return k;
    endfunction

endpackage

// File: rtl/tt_prescaler.sv
`timescale 1ns/1ps
module tt_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] acc;

    // >= keeps the divider sane if P is lowered below a frozen phase.
    assign tick = run && (acc >= div);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (run) begin
            acc <= tick ? '0 : acc + 1'b1;
        end
    end
endmodule

// File: rtl/tt_downcounter.sv
`timescale 1ns/1ps
module tt_downcounter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sreset,
    input  logic             ovw,
    input  logic [CNT_W-1:0] ovw_val,
    input  logic             restart,
    input  logic [CNT_W-1:0] restart_val,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] stepped;

    always_comb begin
        if (count == '0) begin
            stepped = reload ? load_val : ALL_ONES;
        end else begin
            stepped = count - 1'b1;
        end
    end

    // Event only when the tick is what moves the counter onto the compare value.
    assign hit = tick && !sreset && !ovw && !restart && (stepped == cmp_val);

    always_ff @(posedge clk) begin
        if (rst || sreset) begin
            count <= ALL_ONES;
        end else if (ovw) begin
            count <= ovw_val;
        end else if (restart) begin
            count <= restart_val;
        end else if (tick) begin
            count <= stepped;
        end
    end
endmodule

// File: rtl/tt_pin_driver.sv
`timescale 1ns/1ps
module tt_pin_driver
    import tick_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sreset,
    input  logic     hit,
    input  pin_act_e act,
    output logic     pin,
    output logic     oe
);
    assign oe = (act != PIN_OFF);

    always_ff @(posedge clk) begin
        if (rst || sreset) begin
            pin <= 1'b0;
        end else if (hit) begin
            case (act)
                PIN_FLIP: pin <= !pin;
                PIN_LO:   pin <= 1'b0;
                PIN_HI:   pin <= 1'b1;
                default:  pin <= pin;
            endcase
        end
    end
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              bus_err,
    input  logic              stop_mode,
    input  logic              wait_mode,
    input  logic              debug_mode,
    output logic              irq,
    output logic              pin_out,
    output logic              pin_oe
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    ctl_t             ctl;
    ctl_t             ctl_new;
    logic             swr_busy;
    logic             ctl_wait;
    logic             flag;
    logic [CNT_W-1:0] load_r;
    logic [CNT_W-1:0] cmp_r;
    logic [CNT_W-1:0] count;
    logic [DATA_W-1:0] rd_word;

    logic ctl_req, commit, swr_req, ctl_commit;
    logic restart, ovw, lp_freeze, run, tick, hit;

    // Bus handshake: control writes take one wait state.
    assign ctl_req    = bus_wr && (bus_addr == A_CTRL);
    assign bus_ready  = !(ctl_req && !ctl_wait);
    assign commit     = bus_wr && bus_ready;
    assign bus_err    = commit && (bus_addr == A_CNT);
    assign ctl_new    = ctl_unpack(bus_wdata);
    assign swr_req    = commit && (bus_addr == A_CTRL) && bus_wdata[SWR_BIT];
    assign ctl_commit = commit && (bus_addr == A_CTRL) && !bus_wdata[SWR_BIT];

    assign restart = ctl_commit && !ctl.en && ctl_new.en && ctl_new.restart_mode;
    assign ovw     = commit && (bus_addr == A_LOAD) && ctl.ovw;

    assign lp_freeze = (stop_mode && !ctl.stop_run)
                     || (wait_mode && !ctl.wait_run)
                     || (debug_mode && !ctl.dbg_run);
    assign run = ctl.en && (ctl.clk_sel != 2'b00) && !lp_freeze && !swr_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_wait <= 1'b0;
            swr_busy <= 1'b0;
            ctl      <= '0;
        end else begin
            ctl_wait <= ctl_req && !ctl_wait;
            swr_busy <= swr_req;
            if (swr_req) begin
                ctl <= ctl_keep(ctl);
            end else if (ctl_commit) begin
                ctl <= ctl_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || swr_req) begin
            load_r <= ALL_ONES;
            cmp_r  <= '0;
            flag   <= 1'b0;
        end else begin
            if (commit && (bus_addr == A_LOAD)) load_r <= bus_wdata[CNT_W-1:0];
            if (commit && (bus_addr == A_CMP))  cmp_r  <= bus_wdata[CNT_W-1:0];
            if (hit) begin
                flag <= 1'b1;
            end else if (commit && (bus_addr == A_STAT) && bus_wdata[0]) begin
                flag <= 1'b0;
            end
        end
    end

    tt_prescaler #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .clr  (swr_req || restart),
        .run  (run),
        .div  (ctl.div),
        .tick (tick)
    );

    tt_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .sreset      (swr_req),
        .ovw         (ovw),
        .ovw_val     (bus_wdata[CNT_W-1:0]),
        .restart     (restart),
        .restart_val (ctl_new.reload ? load_r : ALL_ONES),
        .tick        (tick),
        .reload      (ctl.reload),
        .load_val    (load_r),
        .cmp_val     (cmp_r),
        .count       (count),
        .hit         (hit)
    );

    tt_pin_driver u_pin (
        .clk    (clk),
        .rst    (rst),
        .sreset (swr_req),
        .hit    (hit),
        .act    (ctl.pin_act),
        .pin    (pin_out),
        .oe     (pin_oe)
    );

    assign irq = flag && ctl.irq_en;

    always_comb begin
        case (bus_addr)
            A_CTRL:  rd_word = ctl_pack(ctl, swr_busy);
            A_STAT:  rd_word = {{(DATA_W-1){1'b0}}, flag};
            A_LOAD:  rd_word = DATA_W'(load_r);
            A_CMP:   rd_word = DATA_W'(cmp_r);
            A_CNT:   rd_word = DATA_W'(count);
            default: rd_word = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_word : '0;
endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_ready,
    input logic              bus_err,
    input logic              en,
    input logic              swr_busy,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic              flag
);
    p_read_no_wait_r2: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> bus_ready);

    p_ctl_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CTRL && bus_ready)
            |-> $past(bus_wr && bus_addr == A_CTRL && !bus_ready));

    p_err_source_r3: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (bus_wr && bus_addr == A_CNT));

    p_frozen_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!en && !bus_wr) |=> $stable(cnt));

    p_flag_on_match_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag) && !$past(bus_wr)) |-> (cnt == cmp));

    p_swr_single_r11: assert property (@(posedge clk) disable iff (rst)
        swr_busy |=> !swr_busy);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .en        (ctl.en),
    .swr_busy  (swr_busy),
    .cnt       (count),
    .cmp       (cmp_r),
    .flag      (flag)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready, bus_err;
    logic        stop_mode = 1'b0, wait_mode = 1'b0, debug_mode = 1'b0;
    logic        irq, pin_out, pin_oe;

    int errors = 0;
    int checks = 0;

    localparam logic [4:0] O_CTRL = 5'h00, O_STAT = 5'h04, O_LOAD = 5'h08,
                           O_CMP = 5'h0C, O_CNT = 5'h10;
    localparam logic [31:0] CLK01 = 32'h0100_0000;

    always #2 clk = !clk;

    tick_timer u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .stop_mode(stop_mode), .wait_mode(wait_mode),
        .debug_mode(debug_mode), .irq(irq), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d,
                             output int waits, output logic err);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        waits = 0;
        #1;
        while (!bus_ready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        err = bus_err;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        int w; logic e;
        bus_write(a, d, w, e);
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [4:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic poll_cnt(input logic [31:0] target);
        logic [31:0] v;
        for (int i = 0; i < 64; i++) begin
            rd(O_CNT, v);
            if (v == target) return;
        end
        check(1'b0, "poll counter", v, target);
    endtask

    task automatic poll_flag();
        logic [31:0] v;
        for (int i = 0; i < 64; i++) begin
            rd(O_STAT, v);
            if (v[0]) return;
        end
        check(1'b0, "poll flag", v, 32'h1);
    endtask

    task automatic t_reset();
        expect_reg(O_CTRL, 32'h0, "R1 ctrl");
        expect_reg(O_STAT, 32'h0, "R1 status");
        expect_reg(O_LOAD, 32'hFFFF_FFFF, "R1 load");
        expect_reg(O_CMP, 32'h0, "R1 compare");
        expect_reg(O_CNT, 32'hFFFF_FFFF, "R1 counter");
        check(!irq && !pin_out && !pin_oe, "R1 outputs", {irq, pin_out, pin_oe}, 0);
    endtask

    task automatic t_bus();
        int w; logic e;
        bus_write(O_CTRL, 32'hFC10_0000, w, e);
        check(w == 1, "R2 ctrl wait state", w, 1);
        expect_reg(O_CTRL, 32'h0, "R3 reserved ctrl bits");
        bus_write(O_LOAD, 32'hFFFF_FFFF, w, e);
        check(w == 0 && !e, "R2 load no wait", w, 0);
        wr(O_STAT, 32'hFFFF_FFFE);
        expect_reg(O_STAT, 32'h0, "R3 reserved status bits");
        bus_write(O_CNT, 32'h1234, w, e);
        check(e == 1'b1 && w == 0, "R3 counter write error", e, 1);
        expect_reg(O_CNT, 32'hFFFF_FFFF, "R3 counter unchanged");
    endtask

    task automatic t_prescale();
        wr(O_CTRL, CLK01);
        wr(O_CTRL, CLK01 | 32'h33);          // P=3, restart, enable
        expect_reg(O_CNT, 32'hFFFF_FFFF, "R6 restart to all ones");
        repeat (20) @(posedge clk);
        expect_reg(O_CNT, 32'hFFFF_FFFA, "R4 divide by 4");
    endtask

    task automatic t_resume();
        logic [31:0] c1, c2;
        wr(O_CTRL, CLK01 | 32'h32);          // disable
        rd(O_CNT, c1);
        repeat (10) @(posedge clk);
        rd(O_CNT, c2);
        check(c2 == c1, "R6 frozen when disabled", c2, c1);
        wr(O_CTRL, CLK01);
        wr(O_CTRL, CLK01 | 32'h1);           // enable, resume mode, P=0
        expect_reg(O_CNT, c1, "R6 resume value");
        repeat (5) @(posedge clk);
        expect_reg(O_CNT, c1 - 5, "R6 resumed counting");
    endtask

    task automatic t_reload();
        wr(O_CTRL, CLK01);
        wr(O_LOAD, 32'd5);
        wr(O_CTRL, CLK01 | 32'hB);
        repeat (8) @(posedge clk);
        expect_reg(O_CNT, 32'd3, "R5 reload from load value");
    endtask

    task automatic t_overwrite();
        logic [31:0] c1;
        wr(O_CTRL, CLK01 | 32'h0002_0003);   // overwrite on, free-running
        wr(O_LOAD, 32'd2);
        expect_reg(O_CNT, 32'd2, "R8 overwrite");
        repeat (3) @(posedge clk);
        expect_reg(O_CNT, 32'hFFFF_FFFF, "R5 wrap to all ones");
        wr(O_CTRL, CLK01);
        rd(O_CNT, c1);
        wr(O_LOAD, 32'h1234);
        expect_reg(O_CNT, c1, "R8 no overwrite when off");
        expect_reg(O_LOAD, 32'h1234, "R8 load stored");
    endtask

    task automatic t_lowpower(input int which, input logic [31:0] run_bit);
        logic [31:0] c1, c2;
        wr(O_CTRL, CLK01);
        wr(O_CTRL, CLK01 | 32'h3);           // restart mode set
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (which == 0) stop_mode = 1'b1; else if (which == 1) wait_mode = 1'b1;
        else debug_mode = 1'b1;
        rd(O_CNT, c1);
        repeat (10) @(posedge clk);
        rd(O_CNT, c2);
        check(c2 == c1, "R7 frozen in low-power mode", c2, c1);
        stop_mode = 1'b0; wait_mode = 1'b0; debug_mode = 1'b0;
        rd(O_CNT, c2);
        check(c2 == c1 - 1, "R7 resume ignores restart mode", c2, c1 - 1);
        wr(O_CTRL, CLK01 | 32'h3 | run_bit);
        @(negedge clk);
        if (which == 0) stop_mode = 1'b1; else if (which == 1) wait_mode = 1'b1;
        else debug_mode = 1'b1;
        rd(O_CNT, c1);
        repeat (4) @(posedge clk);
        rd(O_CNT, c2);
        check(c2 == c1 - 4, "R7 run-enable keeps counting", c2, c1 - 4);
        stop_mode = 1'b0; wait_mode = 1'b0; debug_mode = 1'b0;
    endtask

    task automatic t_clk_off();
        wr(O_CTRL, 32'h0);
        wr(O_CTRL, 32'h3);                   // enabled but clock select 00
        repeat (10) @(posedge clk);
        expect_reg(O_CNT, 32'hFFFF_FFFF, "R12 clock off");
    endtask

    task automatic t_compare();
        wr(O_CTRL, CLK01);
        wr(O_LOAD, 32'd10);
        wr(O_CMP, 32'd7);
        wr(O_STAT, 32'h1);
        wr(O_CTRL, CLK01 | 32'hB);
        repeat (2) @(posedge clk);
        expect_reg(O_STAT, 32'h0, "R9 no flag before match");
        expect_reg(O_STAT, 32'h1, "R9 flag on match");
        check(irq == 1'b0, "R9 irq masked", irq, 0);
        wr(O_CTRL, CLK01 | 32'hF);
        check(irq == 1'b1, "R9 irq enabled", irq, 1);
        wr(O_STAT, 32'h1);
        poll_cnt(32'd9);
        wr(O_STAT, 32'h1);                   // commits on the match edge
        expect_reg(O_STAT, 32'h1, "R9 set wins over clear");
        poll_cnt(32'd3);
        wr(O_STAT, 32'h1);
        expect_reg(O_STAT, 32'h0, "R9 write one clears");
        check(irq == 1'b0, "R9 irq follows flag", irq, 0);
    endtask

    task automatic pin_step(input logic [31:0] om, input logic exp, input string req);
        wr(O_CTRL, CLK01 | 32'hF | om);
        wr(O_STAT, 32'h1);
        poll_flag();
        check(pin_out == exp, req, pin_out, exp);
    endtask

    task automatic t_pins();
        pin_step(32'h0040_0000, 1'b1, "R10 toggle to high");
        check(pin_oe == 1'b1, "R10 drive enabled", pin_oe, 1);
        pin_step(32'h0040_0000, 1'b0, "R10 toggle to low");
        pin_step(32'h00C0_0000, 1'b1, "R10 set high");
        pin_step(32'h0080_0000, 1'b0, "R10 clear low");
        pin_step(32'h0000_0000, 1'b0, "R10 disconnected holds");
        check(pin_oe == 1'b0, "R10 drive disabled", pin_oe, 0);
    endtask

    task automatic t_swreset();
        wr(O_CTRL, 32'h01A8_003E);
        expect_reg(O_CTRL, 32'h01A8_003E, "R11 setup readback");
        wr(O_CTRL, 32'h0001_0000);
        expect_reg(O_CTRL, 32'h0029_0002, "R11 busy bit set");
        expect_reg(O_CTRL, 32'h0028_0002, "R11 kept bits");
        expect_reg(O_LOAD, 32'hFFFF_FFFF, "R11 load reset");
        expect_reg(O_CMP, 32'h0, "R11 compare reset");
        expect_reg(O_STAT, 32'h0, "R11 status reset");
        expect_reg(O_CNT, 32'hFFFF_FFFF, "R11 counter reset");
        check(pin_out == 1'b0, "R11 pin reset", pin_out, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bus();
        t_prescale();
        t_resume();
        t_reload();
        t_overwrite();
        t_lowpower(0, 32'h0020_0000);
        t_lowpower(1, 32'h0008_0000);
        t_lowpower(2, 32'h0004_0000);
        t_clk_off();
        t_compare();
        t_pins();
        t_swreset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule